// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block derives the serial clock of an I2C master from the module clock. A prescaler divides the module clock into a slower internal tick. Two phase timers count those ticks to set how long the serial clock stays low and how long it stays high. Each phase is stretched by a fixed pad of extra ticks, and the size of the pad depends on the prescaler setting. One full period therefore lasts (P+1) x ((L+pad) + (H+pad)) module clocks, where P, L and H are the prescaler, low divider and high divider values.

The generator is held idle with the clock line high while the controller run bit (`run_en`) is clear. Software loads the three divider values during that time. Once the run bit is set, toggling begins when the enable input is raised. The enable normally comes from the transfer logic. A one-cycle strobe marks the end of each phase, so that a data shifter or a START/STOP sequencer can align to the clock edges. The divider inputs are captured at the start of every low phase, so a change made while the clock is running never shortens or stretches a phase that has already begun.

Top module: `scl_clock_gen`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `scl_o` is 1 and `lo_done` and `hi_done` are both 0, whatever the other inputs are.
- R2: While `run_en` is 0, `scl_o` is 1 and both strobes are 0 from the next clock edge on, even if `gen_en` is 1 and a phase was in progress.
- R3: With `run_en` at 1 and `gen_en` at 0 in the idle state, `scl_o` stays 1 and no strobe is raised.
- R4: A low phase lasts exactly (`psc_val`+1) x (`lo_div`+pad) module clock cycles.
- R5: A high phase lasts exactly (`psc_val`+1) x (`hi_div`+pad) module clock cycles.
- R6: The pad is 7 when `psc_val` is 0, 6 when `psc_val` is 1, and 5 when `psc_val` is 2 or more.
- R7: `lo_done` is high for exactly the first cycle in which `scl_o` is 1 after a low phase. `hi_done` is high for exactly the one cycle that follows the last cycle of a high phase.
- R8: New values on `psc_val`, `lo_div` and `hi_div` are captured only when a low phase starts. A change made during a period first affects the next period's low phase and high phase.
- R9: If `gen_en` is cleared during a period, that period completes with its normal low and high lengths. `hi_done` is still raised, and `scl_o` then stays 1 with no further strobes.
- R10: When the block is idle with `run_en` at 1, a clock edge that sees `gen_en` at 1 drives `scl_o` to 0 right after that edge, and this starts a low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Controller run bit; 0 holds the generator idle |
| gen_en | input | 1 | Request to produce clock periods |
| psc_val | input | PSC_W | Prescaler value P; one tick every P+1 clocks |
| lo_div | input | DIV_W | Low-phase divider L |
| hi_div | input | DIV_W | High-phase divider H |
| scl_o | output | 1 | Serial clock drive level |
| lo_done | output | 1 | One-cycle strobe at the end of a low phase |
| hi_done | output | 1 | One-cycle strobe at the end of a high phase |

## Verification
Phase lengths are measured with prescaler settings 0, 1, 2 and 4. These settings exercise all three pad values and show whether the prescaler multiplies the whole phase, pad included, or only the divider. Each setting uses unequal low and high dividers, so a swapped divider or a shared phase timer shows up as a length mismatch. Dividers of zero check that the pad alone sets the minimum phase. Two back-to-back periods are measured to expose drift at the high-to-low seam. Changes made in the middle of a period, a mid-period drop of the enable and a mid-phase drop of the run bit separate capture on low-phase entry, finishing the period and immediate idling.

// File: rtl/scl_gen_pkg.sv
// Package scl_gen_pkg
// Shared state encoding and phase pad constants for the SCL generator.
// Assumes: pad values are small constants fixed by the timing rule.
package scl_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_e;

    localparam int unsigned PAD_P0   = 7;
    localparam int unsigned PAD_P1   = 6;
    localparam int unsigned PAD_PMIN = 5;
    localparam int unsigned PAD_W    = 3;

endpackage

// File: rtl/scl_tick_prescaler.sv
// Module scl_tick_prescaler
// Produces one tick every div+1 clocks while not held.
// Assumes: div only changes while held or in the cycle the counter wraps.
module scl_tick_prescaler #(
    parameter int unsigned PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);

    logic [PSC_W-1:0] cnt_q;

    // Tick when the counter has reached the divide value.
    assign tick = !hold && (cnt_q == div);

    // Counter runs 0..div and restarts; cleared while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PSC_W'(1);
        end
    end

    // R4: the count never passes the divide value, so ticks are evenly spaced
    psc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div)
        else $error("prescaler count beyond divide value");

endmodule

// File: rtl/scl_phase_timer.sv
// Module scl_phase_timer
// Counts prescaler ticks and flags the last tick of a phase of len ticks.
// Assumes: len >= 1 and len only changes when the count is zero.
module scl_phase_timer #(
    parameter int unsigned LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic             last
);

    logic [LEN_W-1:0] cnt_q;
    logic             at_end;

    // The phase ends on the tick that would take the count to len.
    assign at_end = (cnt_q == (len - LEN_W'(1)));
    assign last   = tick && at_end;

    // Tick counter, restarted at each phase end and while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_end ? '0 : cnt_q + LEN_W'(1);
        end
    end

    // R5: the tick count stays below the phase length
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < len)
        else $error("phase count reached its length");

endmodule

// File: rtl/scl_clock_gen.sv
// Module scl_clock_gen
// I2C master SCL generator: prescaled tick, padded low and high phases,
// one-cycle phase-end strobes. Divider inputs are captured at low-phase entry.
// Assumes: run_en clear means the controller is in reset; no clock stretching.
module scl_clock_gen
    import scl_gen_pkg::*;
#(
    parameter int unsigned PSC_W = 8,
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             gen_en,
    input  logic [PSC_W-1:0] psc_val,
    input  logic [DIV_W-1:0] lo_div,
    input  logic [DIV_W-1:0] hi_div,
    output logic             scl_o,
    output logic             lo_done,
    output logic             hi_done
);

    localparam int unsigned LEN_W = DIV_W + 1;

    scl_state_e       state_q;
    logic [PSC_W-1:0] psc_s;
    logic [DIV_W-1:0] lo_s;
    logic [DIV_W-1:0] hi_s;
    logic [PAD_W-1:0] pad;
    logic [LEN_W-1:0] lo_len;
    logic [LEN_W-1:0] hi_len;
    logic [LEN_W-1:0] cur_len;
    logic             hold;
    logic             tick;
    logic             phase_last;

    // Pad chosen from the captured prescaler value.
    always_comb begin
        if (psc_s == '0) begin
            pad = PAD_W'(PAD_P0);
        end else if (psc_s == PSC_W'(1)) begin
            pad = PAD_W'(PAD_P1);
        end else begin
            pad = PAD_W'(PAD_PMIN);
        end
    end

    // Phase lengths in ticks, and the one the timer is counting.
    assign lo_len  = {1'b0, lo_s} + LEN_W'(pad);
    assign hi_len  = {1'b0, hi_s} + LEN_W'(pad);
    assign cur_len = (state_q == ST_LOW) ? lo_len : hi_len;
    assign hold    = !run_en || (state_q == ST_IDLE);

    scl_tick_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .div   (psc_s),
        .tick  (tick)
    );

    scl_phase_timer #(
        .LEN_W (LEN_W)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .tick  (tick),
        .len   (cur_len),
        .last  (phase_last)
    );

    // Phase sequencer: drives SCL, strobes and divider capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            scl_o   <= 1'b1;
            lo_done <= 1'b0;
            hi_done <= 1'b0;
            psc_s   <= '0;
            lo_s    <= '0;
            hi_s    <= '0;
        end else if (!run_en) begin
            state_q <= ST_IDLE;
            scl_o   <= 1'b1;
            lo_done <= 1'b0;
            hi_done <= 1'b0;
            psc_s   <= psc_val;
            lo_s    <= lo_div;
            hi_s    <= hi_div;
        end else begin
            lo_done <= 1'b0;
            hi_done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (gen_en) begin
                        state_q <= ST_LOW;
                        scl_o   <= 1'b0;
                        psc_s   <= psc_val;
                        lo_s    <= lo_div;
                        hi_s    <= hi_div;
                    end
                end
                ST_LOW: begin
                    if (phase_last) begin
                        state_q <= ST_HIGH;
                        scl_o   <= 1'b1;
                        lo_done <= 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (phase_last) begin
                        hi_done <= 1'b1;
                        if (gen_en) begin
                            state_q <= ST_LOW;
                            scl_o   <= 1'b0;
                            psc_s   <= psc_val;
                            lo_s    <= lo_div;
                            hi_s    <= hi_div;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    scl_o   <= 1'b1;
                end
            endcase
        end
    end

    // R7
    lo_strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_done |-> $rose(scl_o))
        else $error("low-phase strobe without SCL rising");

    // R7
    hi_strobe_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_done |-> $past(scl_o))
        else $error("high-phase strobe without a preceding high level");

    // R2
    run_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (scl_o && !lo_done && !hi_done))
        else $error("generator active while run bit clear");

endmodule

// File: tb/scl_clock_gen_tb.sv
module scl_clock_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PSC_W = 8;
    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             run_en;
    logic             gen_en;
    logic [PSC_W-1:0] psc_val;
    logic [DIV_W-1:0] lo_div;
    logic [DIV_W-1:0] hi_div;
    logic             scl_o;
    logic             lo_done;
    logic             hi_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_clock_gen #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .gen_en  (gen_en),
        .psc_val (psc_val),
        .lo_div  (lo_div),
        .hi_div  (hi_div),
        .scl_o   (scl_o),
        .lo_done (lo_done),
        .hi_done (hi_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pad_of(input int p);
        if (p == 0) return 7;
        if (p == 1) return 6;
        return 5;
    endfunction

    // Waits until a negedge where SCL has just fallen.
    task automatic wait_fall();
        logic p;
        int g;
        p = scl_o;
        g = 0;
        @(negedge clk);
        while (!(p == 1'b1 && scl_o == 1'b0) && g < 5000) begin
            p = scl_o;
            g++;
            @(negedge clk);
        end
    endtask

    // Starting at the first low negedge: measures low and high lengths,
    // counts strobe misplacements; ends at the next fall.
    task automatic count_rest(output int lo_c, output int hi_c, output int serr);
        int g;
        lo_c = 1;
        hi_c = 0;
        serr = 0;
        g = 0;
        @(negedge clk);
        while (scl_o == 1'b0 && g < 5000) begin
            if (lo_done !== 1'b0 || hi_done !== 1'b0) serr++;
            lo_c++;
            g++;
            @(negedge clk);
        end
        hi_c = 1;
        if (lo_done !== 1'b1 || hi_done !== 1'b0) serr++;
        @(negedge clk);
        while (scl_o == 1'b1 && g < 10000) begin
            if (lo_done !== 1'b0 || hi_done !== 1'b0) serr++;
            hi_c++;
            g++;
            @(negedge clk);
        end
        if (hi_done !== 1'b1) serr++;
    endtask

    task automatic idle_setup(input int p, input int l, input int h);
        @(negedge clk);
        run_en  = 1'b0;
        gen_en  = 1'b0;
        psc_val = PSC_W'(p);
        lo_div  = DIV_W'(l);
        hi_div  = DIV_W'(h);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; run_en = 1'b1; gen_en = 1'b1;
        psc_val = '0; lo_div = 16'd1; hi_div = 16'd1;
        repeat (3) @(negedge clk);
        check(scl_o === 1'b1, "R1 scl after reset", int'(scl_o), 1);
        check(lo_done === 1'b0 && hi_done === 1'b0, "R1 strobes after reset",
              int'({lo_done, hi_done}), 0);
        run_en = 1'b0; gen_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_gen_off();
        int bad = 0;
        idle_setup(0, 2, 2);
        run_en = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (scl_o !== 1'b1 || lo_done || hi_done) bad++;
        end
        check(bad == 0, "R3 idle with gen_en low", bad, 0);
    endtask

    task automatic t_ratio(input int p, input int l, input int h);
        int lo_c, hi_c, serr, elo, ehi;
        elo = (p + 1) * (l + pad_of(p));
        ehi = (p + 1) * (h + pad_of(p));
        idle_setup(p, l, h);
        run_en = 1'b1;
        gen_en = 1'b1;
        @(negedge clk);
        check(scl_o === 1'b0, "R10 start latency", int'(scl_o), 0);
        count_rest(lo_c, hi_c, serr);
        check(lo_c == elo, "R4 R6 low length", lo_c, elo);
        check(hi_c == ehi, "R5 R6 high length", hi_c, ehi);
        check(serr == 0, "R7 strobe placement", serr, 0);
        count_rest(lo_c, hi_c, serr);
        check(lo_c == elo && hi_c == ehi, "R4 R5 second period",
              lo_c * 1000 + hi_c, elo * 1000 + ehi);
        check(serr == 0, "R7 strobe placement second period", serr, 0);
        run_en = 1'b0;
        gen_en = 1'b0;
    endtask

    task automatic t_update();
        int lo_c, hi_c, serr;
        idle_setup(0, 3, 4);
        run_en = 1'b1;
        gen_en = 1'b1;
        wait_fall();
        lo_div = 16'd10;
        hi_div = 16'd1;
        count_rest(lo_c, hi_c, serr);
        check(lo_c == 10 && hi_c == 11, "R8 current period keeps old values",
              lo_c * 1000 + hi_c, 10 * 1000 + 11);
        count_rest(lo_c, hi_c, serr);
        check(lo_c == 17 && hi_c == 8, "R8 next period uses new values",
              lo_c * 1000 + hi_c, 17 * 1000 + 8);
        run_en = 1'b0;
        gen_en = 1'b0;
    endtask

    task automatic t_stop();
        int lo_c, h, g, bad;
        idle_setup(0, 2, 3);
        run_en = 1'b1;
        gen_en = 1'b1;
        wait_fall();
        gen_en = 1'b0;
        lo_c = 1;
        g = 0;
        @(negedge clk);
        while (scl_o == 1'b0 && g < 5000) begin
            lo_c++; g++;
            @(negedge clk);
        end
        check(lo_c == 9, "R9 low length after enable drop", lo_c, 9);
        h = 1;
        while (!hi_done && g < 5000) begin
            @(negedge clk);
            h++; g++;
        end
        check(h == 11 && scl_o === 1'b1, "R9 final high strobe position", h, 11);
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (scl_o !== 1'b1 || lo_done || hi_done) bad++;
        end
        check(bad == 0, "R9 stays high after last period", bad, 0);
        run_en = 1'b0;
    endtask

    task automatic t_run_drop();
        int bad;
        idle_setup(1, 5, 5);
        run_en = 1'b1;
        gen_en = 1'b1;
        wait_fall();
        repeat (3) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(scl_o === 1'b1 && !lo_done && !hi_done, "R2 immediate idle",
              int'({scl_o, lo_done, hi_done}), 4);
        bad = 0;
        repeat (30) begin
            @(negedge clk);
            if (scl_o !== 1'b1 || lo_done || hi_done) bad++;
        end
        check(bad == 0, "R2 held idle with gen_en high", bad, 0);
        run_en = 1'b1;
        @(negedge clk);
        check(scl_o === 1'b0, "R10 restart after run bit set", int'(scl_o), 0);
        run_en = 1'b0;
        gen_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_gen_off();
        t_ratio(0, 3, 4);
        t_ratio(1, 2, 5);
        t_ratio(2, 1, 0);
        t_ratio(4, 0, 2);
        t_update();
        t_stop();
        t_run_drop();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule